// File: doc/BRIEF.md
# Two-Source Interrupt Controller with Return-Stack Gating

This block decides when a small 8-bit core branches to an interrupt routine. It serves two sources. The first is an external, active-low pin. The second is the overflow pulse of a timer/event counter. One control byte holds a global enable, a per-source enable for each source and a request flag for each source. Software reads and writes this byte at data address 0x0B. A falling edge on the pin, or an overflow pulse from the timer, sets the flag of its source. When the global enable is set, the flag's source is enabled and the return stack has room, the block raises a one-cycle branch request. With that request it gives the vector address and a strobe that pushes the program counter. Nothing else is saved; the status byte is not pushed.

On acknowledge, the block clears the global enable and the flag of the source being served. Nesting is therefore blocked until software sets the enable again, or until the core gives a return-from-interrupt strobe. Events that arrive in the meantime are still recorded in their flags. While the stack-full input is high, no request is acknowledged. The request waits, and it is taken once the stack pointer has been decremented. A wake output tells a halted core that an enabled request is pending.

The sequencer has four states:
- IDLE: waits for an acknowledgeable request.
- HOLD: a request is ready but the stack is full.
- GRANT: the one-cycle branch.
- MASKED: waits for the global enable to return.

Its transitions are:
- IDLE→GRANT when a request is ready and the stack has room.
- IDLE→HOLD when a request is ready and the stack is full.
- HOLD→GRANT when the stack-full input drops.
- HOLD→IDLE when the request disappears.
- GRANT→MASKED always.
- MASKED→IDLE once the global enable is set again.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, branch_req and pc_push are low and wake is low.
- R2: A high-to-low transition on ext_irq_n sets the external flag (bit 4). A low-to-high transition sets nothing.
- R3: A one-cycle high pulse on tmr_ovf sets the timer flag (bit 5).
- R4: When the global enable (bit 0) is set and an enabled source has its flag set, branch_req and pc_push pulse high together for exactly one cycle. The enables are bit 1 for the external source and bit 2 for the timer.
- R5: When both sources are acknowledgeable, the external source is served first with vector 0x004. The timer vector is 0x008.
- R6: An acknowledge clears the global enable and the served source's flag, and leaves the other flag unchanged.
- R7: While the global enable is clear, new events still set their flags but cause no branch.
- R8: While stack_full is high, no branch is issued. A waiting request is taken after stack_full falls.
- R9: A one-cycle reti pulse sets the global enable, and a pending enabled request is then taken.
- R10: wake is high exactly when some source has both its flag and its enable set, whatever the global enable.
- R11: Writes reach the control byte only at address 0x0B. Reads at any other address return 0x00. Bits 3, 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_n | input | 1 | External interrupt pin, asynchronous, active-low |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| stack_full | input | 1 | Return stack has no free slot |
| reti | input | 1 | Return-from-interrupt strobe |
| bus_wr | input | 1 | Data write strobe |
| bus_addr | input | 8 | Data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (control byte at 0x0B, else 0) |
| branch_req | output | 1 | One-cycle branch-to-vector request |
| pc_push | output | 1 | Push program counter onto the return stack |
| branch_vec | output | 12 | Vector address for the branch |
| wake | output | 1 | Enabled request pending, leave halt |

## Verification
Each result has a fixed latency:
- A falling edge on the pin reaches its flag two clock edges after the first synchronizer flop samples it. The branch follows one edge after that.
- A timer pulse sets its flag at the next edge, and GRANT is entered one edge later.
- Register writes are visible one edge after the strobe.

The bench drives inputs and samples outputs on the falling clock edge. For each expected branch it queues a vector, and the monitor compares the queue entry against every branch_req cycle it sees. After each stimulus the bench waits a window several cycles longer than the longest latency, then requires the queue to be empty. In stalled or masked windows, any branch that appears is reported as unexpected.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_GRANT,
        ST_MASKED
    } seq_state_e;

    typedef enum logic {
        SRC_EXT,
        SRC_TMR
    } irq_src_e;

    localparam int unsigned BIT_GIE   = 0;
    localparam int unsigned BIT_EXTEN = 1;
    localparam int unsigned BIT_TMREN = 2;
    localparam int unsigned BIT_EXTFL = 4;
    localparam int unsigned BIT_TMRFL = 5;

endpackage

// File: rtl/pin_fall_detect.sv
module pin_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int unsigned LAST = STAGES - 1;

    // chain[0..STAGES-1] synchronizer, chain[STAGES] previous synced value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= pin;
        end
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign fall = chain[STAGES] & ~chain[LAST];

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_gate_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_evt,
    input  logic              tmr_evt,
    input  logic              ack,
    input  irq_src_e          ack_src,
    input  logic              reti,
    output logic              gie,
    output logic              ext_en,
    output logic              tmr_en,
    output logic              ext_flag,
    output logic              tmr_flag,
    output logic [DATA_W-1:0] reg_val
);
    logic gie_d, ext_en_d, tmr_en_d, ext_flag_d, tmr_flag_d;

    always_comb begin
        gie_d      = gie;
        ext_en_d   = ext_en;
        tmr_en_d   = tmr_en;
        ext_flag_d = ext_flag;
        tmr_flag_d = tmr_flag;
        if (wr_hit) begin
            gie_d      = wdata[BIT_GIE];
            ext_en_d   = wdata[BIT_EXTEN];
            tmr_en_d   = wdata[BIT_TMREN];
            ext_flag_d = wdata[BIT_EXTFL];
            tmr_flag_d = wdata[BIT_TMRFL];
        end
        if (reti) gie_d = 1'b1;
        if (ack) begin
            gie_d = 1'b0;
            if (ack_src == SRC_EXT) ext_flag_d = 1'b0;
            else                    tmr_flag_d = 1'b0;
        end
        // new events are always recorded
        if (ext_evt) ext_flag_d = 1'b1;
        if (tmr_evt) tmr_flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie      <= 1'b0;
            ext_en   <= 1'b0;
            tmr_en   <= 1'b0;
            ext_flag <= 1'b0;
            tmr_flag <= 1'b0;
        end else begin
            gie      <= gie_d;
            ext_en   <= ext_en_d;
            tmr_en   <= tmr_en_d;
            ext_flag <= ext_flag_d;
            tmr_flag <= tmr_flag_d;
        end
    end

    always_comb begin
        reg_val            = '0;
        reg_val[BIT_GIE]   = gie;
        reg_val[BIT_EXTEN] = ext_en;
        reg_val[BIT_TMREN] = tmr_en;
        reg_val[BIT_EXTFL] = ext_flag;
        reg_val[BIT_TMRFL] = tmr_flag;
    end

    // R2: an edge event always lands in the flag
    a_r2_ext_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |=> ext_flag);
    // R3: a timer pulse always lands in the flag
    a_r3_tmr_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> tmr_flag);
    // R6: acknowledge masks further interrupts
    a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !gie);

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     gie,
    input  logic     pend_ext,
    input  logic     pend_tmr,
    input  logic     stack_full,
    output logic     grant,
    output irq_src_e grant_src
);
    seq_state_e state_q, state_d;
    irq_src_e   src_q, src_d;
    logic       ready;

    assign ready = gie & (pend_ext | pend_tmr);

    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ready) state_d = stack_full ? ST_HOLD : ST_GRANT;
            end
            ST_HOLD: begin
                if (!ready)           state_d = ST_IDLE;
                else if (!stack_full) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                state_d = ST_MASKED;
            end
            ST_MASKED: begin
                if (gie) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_d == ST_GRANT && state_q != ST_GRANT)
            src_d = pend_ext ? SRC_EXT : SRC_TMR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_EXT;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        grant     = (state_q == ST_GRANT);
        grant_src = src_q;
    end

    // R8: a grant never follows a cycle with the stack full
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT) |-> !$past(stack_full));
    // R7: with global enable clear the masked state cannot grant
    a_r7_masked_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASKED && !gie) |=> (state_q != ST_GRANT));

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_gate_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PC_W        = 12,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0B,
    parameter logic [PC_W-1:0]   EXT_VEC  = 12'h004,
    parameter logic [PC_W-1:0]   TMR_VEC  = 12'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_irq_n,
    input  logic              tmr_ovf,
    input  logic              stack_full,
    input  logic              reti,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              branch_req,
    output logic              pc_push,
    output logic [PC_W-1:0]   branch_vec,
    output logic              wake
);
    logic        ext_fall;
    logic        addr_hit;
    logic        gie, ext_en, tmr_en, ext_flag, tmr_flag;
    logic        grant;
    irq_src_e    grant_src;
    logic [DATA_W-1:0] reg_val;

    assign addr_hit = (bus_addr == CTL_ADDR);

    pin_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_irq_n),
        .fall (ext_fall)
    );

    irq_ctl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (bus_wr & addr_hit),
        .wdata   (bus_wdata),
        .ext_evt (ext_fall),
        .tmr_evt (tmr_ovf),
        .ack     (grant),
        .ack_src (grant_src),
        .reti    (reti),
        .gie     (gie),
        .ext_en  (ext_en),
        .tmr_en  (tmr_en),
        .ext_flag(ext_flag),
        .tmr_flag(tmr_flag),
        .reg_val (reg_val)
    );

    irq_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gie       (gie),
        .pend_ext  (ext_flag & ext_en),
        .pend_tmr  (tmr_flag & tmr_en),
        .stack_full(stack_full),
        .grant     (grant),
        .grant_src (grant_src)
    );

    always_comb begin
        branch_req = grant;
        pc_push    = grant;
        branch_vec = (grant_src == SRC_EXT) ? EXT_VEC : TMR_VEC;
        wake       = (ext_flag & ext_en) | (tmr_flag & tmr_en);
        bus_rdata  = addr_hit ? reg_val : '0;
    end

    // R4: a branch request lasts a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        branch_req |=> !branch_req);
    // R9: a return strobe re-arms the global enable
    a_r9_reti_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !grant) |=> bus_rdata[BIT_GIE] || (bus_addr != CTL_ADDR) || $past(bus_addr) != bus_addr || $past(bus_wr));

endmodule

// File: tb/sim_irq_gate_ctrl.sv
module sim_irq_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_irq_n = 1'b1;
    logic        tmr_ovf = 1'b0;
    logic        stack_full = 1'b0;
    logic        reti = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0B;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        branch_req, pc_push, wake;
    logic [11:0] branch_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [11:0] exp_q[$];

    always #5 clk = ~clk;

    irq_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
        .stack_full(stack_full), .reti(reti), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .branch_req(branch_req), .pc_push(pc_push), .branch_vec(branch_vec),
        .wake(wake)
    );

    // monitor: every branch must match the next queued vector
    always @(negedge clk) begin
        if (rst_n && branch_req) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4/R7/R8: unexpected branch vec=%h expected none", branch_vec);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                if (branch_vec !== e || pc_push !== 1'b1) begin
                    errors++;
                    $display("FAIL R5: vec=%h push=%b expected vec=%h push=1", branch_vec, pc_push, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected <20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h0B;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected %h", req, bus_rdata, exp);
        end
        bus_addr = 8'h0B;
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_drained(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d branches outstanding expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic pulse_reti();
        reti = 1'b1; @(negedge clk); reti = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_reg("R1", 8'h0B, 8'h00);
        chk_bit("R1 branch", branch_req, 1'b0);
        chk_bit("R1 wake", wake, 1'b0);

        // R4/R6: external branch with vector 0x004
        wr(8'h0B, 8'h03);
        exp_q.push_back(12'h004);
        ext_irq_n = 1'b0;
        idle(8);
        chk_drained("R4");
        chk_reg("R6", 8'h0B, 8'h02);
        ext_irq_n = 1'b1;
        idle(4);

        // R7: masked, new edge recorded, no branch
        ext_irq_n = 1'b0;
        idle(8);
        chk_reg("R7", 8'h0B, 8'h12);
        chk_bit("R10 wake masked", wake, 1'b1);

        // R9: reti re-arms and takes pending request
        exp_q.push_back(12'h004);
        pulse_reti();
        idle(8);
        chk_drained("R9");
        chk_reg("R9", 8'h0B, 8'h02);
        ext_irq_n = 1'b1;
        idle(4);

        // R5/R6: both pending, ext first, timer flag kept
        wr(8'h0B, 8'h36);
        idle(4);
        chk_drained("R7 no branch gie=0");
        exp_q.push_back(12'h004);
        wr(8'h0B, 8'h37);
        idle(8);
        chk_drained("R5");
        chk_reg("R6 other kept", 8'h0B, 8'h26);
        exp_q.push_back(12'h008);
        pulse_reti();
        idle(8);
        chk_drained("R5 timer");
        chk_reg("R5", 8'h0B, 8'h06);

        // R8/R3: stack full blocks the timer request
        stack_full = 1'b1;
        wr(8'h0B, 8'h05);
        tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
        idle(12);
        chk_reg("R3", 8'h0B, 8'h25);
        chk_drained("R8 blocked");
        exp_q.push_back(12'h008);
        stack_full = 1'b0;
        idle(8);
        chk_drained("R8 released");
        chk_reg("R8", 8'h0B, 8'h04);

        // R2/R10: disabled source gets flag, no wake, no branch
        wr(8'h0B, 8'h01);
        ext_irq_n = 1'b0;
        idle(8);
        chk_reg("R2", 8'h0B, 8'h11);
        chk_bit("R10 no enable", wake, 1'b0);
        wr(8'h0B, 8'h01);
        ext_irq_n = 1'b1;
        idle(8);
        chk_reg("R2 rising", 8'h0B, 8'h01);

        // R11: other address ignored and reads zero; unused bits zero
        wr(8'h0A, 8'hFF);
        chk_reg("R11", 8'h0B, 8'h01);
        chk_reg("R11 other", 8'h0A, 8'h00);
        wr(8'h0B, 8'hC8);
        chk_reg("R11 unused", 8'h0B, 8'h00);
        idle(4);
        chk_drained("R11 no branch");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule